// File: doc/BRIEF.md
# Width-Converting Synchronous FIFO with Mark and Replay

This block is a single-clock first-in first-out buffer whose write and read ports can run at different word widths. Storage is a ring of full-width entries (40 bits by default). A narrow writer supplies quarter-width or half-width pieces that are gathered into one entry. A narrow reader takes an entry back out piece by piece. One of the two ports is always full width.

A reader can pin the entry it is about to consume by holding a mark input high. A replay pulse later rewinds the read side to that pinned entry, which allows a frame to be sent again. While the pin is held, the pinned entry and everything after it count as occupied, so the writer can never overwrite data that may still be replayed.

Two flag timing styles are available:
- **Standard:** the flags report empty and full, and read data appears one clock after a read request.
- **Look-ahead:** the oldest piece is placed on the output without a request, and the flags report "output holds data" and "input can accept".

Width pairing and timing style are captured under master reset. Partial reset empties the buffer but keeps that configuration.

Top module: `bm_fifo`

## Requirements
- R1: Width codes are 0 = full width, 1 = half width, 2 = quarter width, and 3 is treated as full width. The codes and the timing style are captured on every clock edge where mrst is high. If both captured widths are narrow, the read width is forced to full.
- R2: After either reset, the buffer is empty and rd_data is zero. In standard style, rd_flag = 1 and wr_flag = 0. In look-ahead style, rd_flag = 0 and wr_flag = 1.
- R3: A narrow write places its piece from the low bits of wr_data. Pieces fill an entry from the least significant end upward. The entry is stored only on the edge that accepts its final piece.
- R4: A narrow read delivers pieces of an entry from the least significant end upward. Each piece sits in the low bits of rd_data, with the upper bits zero. The read position moves to the next entry only after the final piece.
- R5: A write piece is taken only when wr_cs and wr_en are both high and the buffer is not full. Otherwise the piece is dropped.
- R6: In standard style, rd_data is loaded on an edge where rd_cs and rd_en are both high and the buffer is not empty. In every other cycle rd_data holds its value.
- R7: In standard style, rd_flag is 1 exactly when no entry is stored. wr_flag is 1 when DEPTH entries are stored. The edge that stores an entry into an empty buffer clears rd_flag.
- R8: In look-ahead style, the oldest piece is shown on rd_data with rd_flag = 1, without any request. A request (rd_cs and rd_en high) consumes it on the next edge. After an entry is stored into an empty buffer, rd_flag rises on the following edge.
- R9: In look-ahead style, wr_flag is 1 exactly when the buffer can accept a write. The entry shown on the output counts as occupied.
- R10: When mark goes high, the entry holding the next piece to deliver is captured and kept while mark stays high. A replay (retx high while mark was high in the previous cycle) restarts reading from the first piece of that entry. A replay takes priority over a read in the same cycle. A replay is ignored when no mark is held.
- R11: While a mark is held, the marked entry and all later stored entries count toward fullness.
- R12: Partial reset (prst) keeps the captured widths and timing style. Master reset loads new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| mrst | input | 1 | Synchronous master reset; captures configuration |
| prst | input | 1 | Synchronous partial reset; keeps configuration |
| cfg_wr_width | input | 2 | Write width code, sampled under mrst |
| cfg_rd_width | input | 2 | Read width code, sampled under mrst |
| cfg_fwft | input | 1 | 1 selects look-ahead flag timing, sampled under mrst |
| wr_cs | input | 1 | Write chip select, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | ENTRY_W | Write piece, low-aligned when narrow |
| rd_cs | input | 1 | Read chip select, active high |
| rd_en | input | 1 | Read request |
| rd_data | output | ENTRY_W | Read piece, low-aligned and zero-extended |
| mark | input | 1 | Level; holding high pins the current read entry |
| retx | input | 1 | Replay from the pinned entry |
| rd_flag | output | 1 | Empty (standard) or output ready (look-ahead) |
| wr_flag | output | 1 | Full (standard) or input ready (look-ahead) |

## Verification
The assertions assume the following about the inputs:
- Resets are synchronous, so they are disabled during either reset.
- mrst is high at time zero, so the captured configuration is never unknown.
- mark is treated as a level: replay only has meaning one cycle after mark has risen.

The stimulus respects these assumptions:
- Every scenario starts with a two-cycle master reset.
- Inputs change one time unit after a rising edge.
- mark is raised in a cycle of its own before any replay pulse.
- The width codes stay constant outside master reset.

// File: rtl/bm_fifo_pkg.sv
package bm_fifo_pkg;

  typedef enum logic [1:0] {
    WID_40  = 2'd0,
    WID_20  = 2'd1,
    WID_10  = 2'd2,
    WID_RSV = 2'd3
  } width_e;

  // Reserved code behaves as full width.
  function automatic width_e width_norm(input logic [1:0] code);
    return (code == 2'd3) ? WID_40 : width_e'(code);
  endfunction

  function automatic logic is_narrow(input width_e w);
    return (w == WID_20) || (w == WID_10);
  endfunction

  // Index of the final piece of an entry.
  function automatic logic [1:0] last_lane(input width_e w);
    case (w)
      WID_20:  return 2'd1;
      WID_10:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // log2 of the number of quarters carried by one piece.
  function automatic logic [1:0] lane_shift(input width_e w);
    case (w)
      WID_20:  return 2'd1;
      WID_10:  return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

  // Mask selecting the quarter index inside one piece.
  function automatic logic [1:0] quarter_mask(input width_e w);
    case (w)
      WID_20:  return 2'd1;
      WID_10:  return 2'd0;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/bm_wr_pack.sv
module bm_wr_pack
  import bm_fifo_pkg::*;
#(
  parameter int ENTRY_W = 40
) (
  input  logic               clk,
  input  logic               clr,
  input  width_e             mode,
  input  logic               push,
  input  logic [ENTRY_W-1:0] din,
  output logic               commit,
  output logic [ENTRY_W-1:0] word
);
  localparam int QW = ENTRY_W / 4;

  logic [1:0]         lane_q;
  logic [ENTRY_W-1:0] acc_q;
  logic [ENTRY_W-1:0] merged;

  // Each quarter of the entry belongs to exactly one piece index.
  always_comb begin
    merged = acc_q;
    for (int qi = 0; qi < 4; qi++) begin
      if ((2'(qi) >> lane_shift(mode)) == lane_q)
        merged[qi*QW +: QW] = din[int'(2'(qi) & quarter_mask(mode))*QW +: QW];
    end
  end

  assign commit = push && (lane_q == last_lane(mode));
  assign word   = merged;

  always_ff @(posedge clk) begin
    if (clr) begin
      lane_q <= 2'd0;
      acc_q  <= '0;
    end else if (push) begin
      lane_q <= commit ? 2'd0 : lane_q + 2'd1;
      acc_q  <= commit ? '0 : merged;
    end
  end

endmodule

// File: rtl/bm_store.sv
module bm_store #(
  parameter int ENTRY_W = 40,
  parameter int DEPTH   = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [ENTRY_W-1:0]       wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [ENTRY_W-1:0]       rdata
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/bm_rd_stage.sv
module bm_rd_stage
  import bm_fifo_pkg::*;
#(
  parameter int ENTRY_W = 40,
  parameter int DEPTH   = 16
) (
  input  logic                       clk,
  input  logic                       clr,
  input  width_e                     mode,
  input  logic                       load,
  input  logic                       pop,
  input  logic                       flush,
  input  logic [ENTRY_W-1:0]         word,
  input  logic [1:0]                 lane,
  input  logic [$clog2(DEPTH):0]     entry_in,
  output logic [ENTRY_W-1:0]         data,
  output logic                       valid,
  output logic [$clog2(DEPTH):0]     entry
);
  localparam int QW = ENTRY_W / 4;

  logic [ENTRY_W-1:0] piece;

  // Select the quarters of the current piece and zero the rest.
  always_comb begin
    piece = '0;
    for (int j = 0; j < 4; j++) begin
      if ((2'(j) & ~quarter_mask(mode)) == 2'd0)
        piece[j*QW +: QW] = word[int'((lane << lane_shift(mode)) | 2'(j))*QW +: QW];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      data  <= '0;
      valid <= 1'b0;
      entry <= '0;
    end else begin
      if (flush)      valid <= 1'b0;
      else if (load)  valid <= 1'b1;
      else if (pop)   valid <= 1'b0;
      if (load) begin
        data  <= piece;
        entry <= entry_in;
      end
    end
  end

endmodule

// File: rtl/bm_ptr_ctrl.sv
module bm_ptr_ctrl
  import bm_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   clr,
  input  width_e                 rmode,
  input  logic                   commit,
  input  logic                   fetch,
  input  logic                   retx_go,
  input  logic                   mark_in,
  input  logic [$clog2(DEPTH):0] head,
  output logic [$clog2(DEPTH):0] wptr,
  output logic [$clog2(DEPTH):0] rptr,
  output logic [1:0]             rd_lane,
  output logic                   mark_valid,
  output logic [$clog2(DEPTH):0] mark_ptr,
  output logic                   full,
  output logic                   empty
);
  localparam int PW = $clog2(DEPTH) + 1;

  logic [PW-1:0] tail;
  logic [PW-1:0] occ;
  logic          rd_last;

  assign tail    = mark_valid ? mark_ptr : head;
  assign occ     = wptr - tail;
  assign full    = (occ == PW'(DEPTH));
  assign empty   = (wptr == rptr);
  assign rd_last = (rd_lane == last_lane(rmode));

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr       <= '0;
      rptr       <= '0;
      rd_lane    <= 2'd0;
      mark_valid <= 1'b0;
      mark_ptr   <= '0;
    end else begin
      if (commit) wptr <= wptr + PW'(1);
      if (retx_go) begin
        rptr    <= mark_ptr;
        rd_lane <= 2'd0;
      end else if (fetch) begin
        if (rd_last) begin
          rptr    <= rptr + PW'(1);
          rd_lane <= 2'd0;
        end else begin
          rd_lane <= rd_lane + 2'd1;
        end
      end
      mark_valid <= mark_in;
      if (mark_in && !mark_valid) mark_ptr <= head;
    end
  end

endmodule

// File: rtl/bm_fifo.sv
module bm_fifo
  import bm_fifo_pkg::*;
#(
  parameter int ENTRY_W = 40,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               mrst,
  input  logic               prst,
  input  logic [1:0]         cfg_wr_width,
  input  logic [1:0]         cfg_rd_width,
  input  logic               cfg_fwft,
  input  logic               wr_cs,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               rd_cs,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  input  logic               mark,
  input  logic               retx,
  output logic               rd_flag,
  output logic               wr_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  width_e wmode_q, rmode_q;
  logic   fwft_q;

  always_ff @(posedge clk) begin
    if (mrst) begin
      wmode_q <= width_norm(cfg_wr_width);
      rmode_q <= (is_narrow(width_norm(cfg_wr_width)) && is_narrow(width_norm(cfg_rd_width)))
                 ? WID_40 : width_norm(cfg_rd_width);
      fwft_q  <= cfg_fwft;
    end
  end

  logic               clr;
  logic               full_w, empty_w;
  logic               wr_fire, commit;
  logic [ENTRY_W-1:0] commit_word, head_word;
  logic               ov, pop, fetch, retx_go;
  logic [PW-1:0]      wptr, rptr, mark_ptr, out_entry, head;
  logic [1:0]         rd_lane;
  logic               mark_valid;

  assign clr     = mrst || prst;
  assign wr_fire = wr_cs && wr_en && !full_w;
  assign retx_go = retx && mark_valid;
  assign pop     = fwft_q && ov && rd_cs && rd_en;
  assign fetch   = !retx_go && !empty_w && (fwft_q ? (!ov || pop) : (rd_cs && rd_en));
  assign head    = (fwft_q && ov) ? out_entry : rptr;

  bm_wr_pack #(.ENTRY_W(ENTRY_W)) u_pack (
    .clk    (clk),
    .clr    (clr),
    .mode   (wmode_q),
    .push   (wr_fire),
    .din    (wr_data),
    .commit (commit),
    .word   (commit_word)
  );

  bm_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (commit),
    .waddr (wptr[AW-1:0]),
    .wdata (commit_word),
    .raddr (rptr[AW-1:0]),
    .rdata (head_word)
  );

  bm_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .clr        (clr),
    .rmode      (rmode_q),
    .commit     (commit),
    .fetch      (fetch),
    .retx_go    (retx_go),
    .mark_in    (mark),
    .head       (head),
    .wptr       (wptr),
    .rptr       (rptr),
    .rd_lane    (rd_lane),
    .mark_valid (mark_valid),
    .mark_ptr   (mark_ptr),
    .full       (full_w),
    .empty      (empty_w)
  );

  bm_rd_stage #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_rd (
    .clk      (clk),
    .clr      (clr),
    .mode     (rmode_q),
    .load     (fetch),
    .pop      (pop),
    .flush    (retx_go),
    .word     (head_word),
    .lane     (rd_lane),
    .entry_in (rptr),
    .data     (rd_data),
    .valid    (ov),
    .entry    (out_entry)
  );

  assign rd_flag = fwft_q ? ov : empty_w;
  assign wr_flag = fwft_q ? !full_w : full_w;

endmodule

// File: rtl/bm_fifo_chk.sv
module bm_fifo_chk
  import bm_fifo_pkg::*;
#(
  parameter int ENTRY_W = 40,
  parameter int DEPTH   = 16
) (
  input logic                   clk,
  input logic                   mrst,
  input logic                   prst,
  input width_e                 wmode,
  input width_e                 rmode,
  input logic                   fwft,
  input logic                   full,
  input logic                   empty,
  input logic                   ov,
  input logic                   pop,
  input logic                   retx_go,
  input logic [ENTRY_W-1:0]     rd_data,
  input logic [$clog2(DEPTH):0] wptr,
  input logic [$clog2(DEPTH):0] rptr,
  input logic [1:0]             rd_lane,
  input logic                   mark_in,
  input logic                   mark_valid,
  input logic [$clog2(DEPTH):0] mark_ptr
);
  localparam int PW = $clog2(DEPTH) + 1;

  a_r1_pair_legal: assert property (@(posedge clk) disable iff (mrst)
    !(is_narrow(wmode) && is_narrow(rmode)));

  a_r2_reset_empty: assert property (@(posedge clk)
    mrst |=> (empty && !ov && rd_data == '0));

  a_r5_full_blocks_write: assert property (@(posedge clk) disable iff (mrst || prst)
    full |=> $stable(wptr));

  a_r6_empty_read_ignored: assert property (@(posedge clk) disable iff (mrst || prst)
    (!fwft && empty && !retx_go) |=> ($stable(rptr) && $stable(rd_lane) && $stable(rd_data)));

  a_r8_head_held: assert property (@(posedge clk) disable iff (mrst || prst)
    (fwft && ov && !pop && !retx_go) |=> (ov && $stable(rd_data)));

  a_r10_retx_rewinds: assert property (@(posedge clk) disable iff (mrst || prst)
    retx_go |=> (rptr == $past(mark_ptr) && rd_lane == 2'd0));

  a_r10_mark_kept: assert property (@(posedge clk) disable iff (mrst || prst)
    (mark_valid && mark_in) |=> $stable(mark_ptr));

  a_r11_mark_guard: assert property (@(posedge clk) disable iff (mrst || prst)
    (mark_valid && (wptr - mark_ptr) == PW'(DEPTH)) |-> full);

  a_r12_prst_keeps_cfg: assert property (@(posedge clk) disable iff (mrst)
    prst |=> ($stable(wmode) && $stable(rmode) && $stable(fwft)));

endmodule

bind bm_fifo bm_fifo_chk #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .mrst       (mrst),
  .prst       (prst),
  .wmode      (wmode_q),
  .rmode      (rmode_q),
  .fwft       (fwft_q),
  .full       (full_w),
  .empty      (empty_w),
  .ov         (ov),
  .pop        (pop),
  .retx_go    (retx_go),
  .rd_data    (rd_data),
  .wptr       (wptr),
  .rptr       (rptr),
  .rd_lane    (rd_lane),
  .mark_in    (mark),
  .mark_valid (mark_valid),
  .mark_ptr   (mark_ptr)
);

// File: tb/bm_fifo_tb.sv
module bm_fifo_tb;
  localparam int EW = 40;
  localparam int DP = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          mrst = 1'b1, prst = 1'b0;
  logic [1:0]    cfg_w = 2'd0, cfg_r = 2'd0;
  logic          cfg_f = 1'b0;
  logic          wr_cs = 1'b0, wr_en = 1'b0, rd_cs = 1'b0, rd_en = 1'b0;
  logic          mark = 1'b0, retx = 1'b0;
  logic [EW-1:0] wr_data = '0;
  logic [EW-1:0] rd_data;
  logic          rd_flag, wr_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bm_fifo #(.ENTRY_W(EW), .DEPTH(DP)) u_dut (
    .clk(clk), .mrst(mrst), .prst(prst),
    .cfg_wr_width(cfg_w), .cfg_rd_width(cfg_r), .cfg_fwft(cfg_f),
    .wr_cs(wr_cs), .wr_en(wr_en), .wr_data(wr_data),
    .rd_cs(rd_cs), .rd_en(rd_en), .rd_data(rd_data),
    .mark(mark), .retx(retx), .rd_flag(rd_flag), .wr_flag(wr_flag)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic master(input logic [1:0] w, input logic [1:0] r, input logic f);
    cfg_w = w; cfg_r = r; cfg_f = f;
    mrst = 1'b1; tick(); tick(); mrst = 1'b0;
  endtask

  task automatic put(input logic [EW-1:0] v);
    wr_cs = 1'b1; wr_en = 1'b1; wr_data = v;
    tick();
    wr_cs = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic get(output logic [EW-1:0] v);
    rd_cs = 1'b1; rd_en = 1'b1;
    tick();
    rd_cs = 1'b0; rd_en = 1'b0;
    v = rd_data;
  endtask

  function automatic int lanes(input logic [1:0] c);
    return (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 1;
  endfunction

  function automatic logic [EW-1:0] low_mask(input int bits);
    logic [EW-1:0] one = EW'(1);
    return (one << bits) - one;
  endfunction

  function automatic logic [EW-1:0] pat(input int k, input int seed);
    return (EW'(k + 1) * 40'h00_9E37_79B9) ^ (EW'(seed) * 40'h37_0000_0137);
  endfunction

  // Fill to capacity, try one extra piece, then drain and compare.
  task automatic run_pair(input logic [1:0] w, input logic [1:0] r, input logic f, input int seed);
    int wl, rl, ww, rw;
    logic [EW-1:0] ent [DP];
    logic [EW-1:0] v, exp;
    wl = lanes(w); rl = lanes(r); ww = EW / wl; rw = EW / rl;
    master(w, r, f);
    for (int e = 0; e < DP; e++) ent[e] = '0;
    for (int k = 0; k < DP * wl; k++) begin
      v = pat(k, seed) & low_mask(ww);
      ent[k / wl] = ent[k / wl] | (v << ((k % wl) * ww));
      put(v);
    end
    tick(); tick();
    if (!f) check1("R7 full flag at capacity", wr_flag, 1'b1);
    else    check1("R9 input ready low at capacity", wr_flag, 1'b0);
    put(pat(999, seed) & low_mask(ww)); // R5: dropped while full
    exp = '0;
    for (int j = 0; j < DP * rl; j++) begin
      exp = (ent[j / rl] >> ((j % rl) * rw)) & low_mask(rw);
      if (f) begin
        check1("R8 output ready while data held", rd_flag, 1'b1);
        check("R8/R3/R4 look-ahead piece", rd_data, exp);
        get(v);
      end else begin
        get(v);
        check("R3/R4/R6 standard piece", v, exp);
      end
    end
    if (!f) begin
      check1("R5/R7 empty after drain, extra write dropped", rd_flag, 1'b1);
      get(v);
      check("R6 read on empty holds data", v, exp);
    end else begin
      check1("R5/R8 output ready low after drain", rd_flag, 1'b0);
      check1("R9 input ready after drain", wr_flag, 1'b1);
    end
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [EW-1:0] v, x, e [4];
    // R2 reset state in both styles
    master(2'd0, 2'd0, 1'b0);
    check1("R2 std rd_flag after reset", rd_flag, 1'b1);
    check1("R2 std wr_flag after reset", wr_flag, 1'b0);
    check("R2 rd_data after reset", rd_data, '0);
    master(2'd0, 2'd0, 1'b1);
    check1("R2 la rd_flag after reset", rd_flag, 1'b0);
    check1("R2 la wr_flag after reset", wr_flag, 1'b1);

    // R1 R3 R4 R5 R6 R7 R8 R9 sweep over the legal pairs and both styles
    for (int f = 0; f < 2; f++) begin
      run_pair(2'd0, 2'd0, f[0], 1 + f);
      run_pair(2'd0, 2'd1, f[0], 3 + f);
      run_pair(2'd0, 2'd2, f[0], 5 + f);
      run_pair(2'd1, 2'd0, f[0], 7 + f);
      run_pair(2'd2, 2'd0, f[0], 9 + f);
    end

    // R7 and R8 first-word latency
    master(2'd0, 2'd0, 1'b0);
    put(40'hAB_CDEF_0123);
    check1("R7 empty clears on commit edge", rd_flag, 1'b0);
    master(2'd0, 2'd0, 1'b1);
    put(40'h12_3456_789A);
    check1("R8 ready not yet on commit edge", rd_flag, 1'b0);
    tick();
    check1("R8 ready one edge after commit", rd_flag, 1'b1);
    check("R8 head shown without request", rd_data, 40'h12_3456_789A);

    // R5 chip select gating on write
    master(2'd0, 2'd0, 1'b0);
    wr_en = 1'b1; wr_cs = 1'b0; wr_data = 40'h55;
    tick();
    wr_en = 1'b0;
    check1("R5 write with cs low ignored", rd_flag, 1'b1);

    // R6 chip select gating on read
    put(40'h00_0000_0A0A); put(40'h00_0000_0B0B);
    rd_en = 1'b1; rd_cs = 1'b0; tick(); rd_en = 1'b0;
    check("R6 read with cs low ignored", rd_data, '0);
    get(v);
    check("R6 next read gives oldest", v, 40'h00_0000_0A0A);

    // R1 illegal pairing forces full-width reads
    master(2'd1, 2'd2, 1'b0);
    put(40'h0_0000_ABCDE & low_mask(20)); put(40'h0_0000_12345);
    get(v);
    check("R1 illegal pair reads full width", v, 40'h12345_ABCDE);
    check1("R1 one entry consumed", rd_flag, 1'b1);
    // R1 reserved code behaves as full width
    master(2'd3, 2'd3, 1'b0);
    put(40'hF0_1E2D_3C4B);
    get(v);
    check("R1 reserved code is full width", v, 40'hF0_1E2D_3C4B);

    // R10 mark and replay, full-width write and quarter-width read
    master(2'd0, 2'd2, 1'b0);
    for (int i = 0; i < 4; i++) begin
      e[i] = pat(i, 77);
      put(e[i]);
    end
    for (int i = 0; i < 4; i++) get(v);
    mark = 1'b1; tick();            // pins entry 1
    for (int i = 0; i < 8; i++) get(v);
    retx = 1'b1; tick(); retx = 1'b0;
    for (int i = 0; i < 4; i++) begin
      get(v);
      check("R10 replay restarts at marked entry", v, (e[1] >> (10 * i)) & low_mask(10));
    end
    x = rd_data;
    retx = 1'b1; rd_cs = 1'b1; rd_en = 1'b1; tick();
    retx = 1'b0; rd_cs = 1'b0; rd_en = 1'b0;
    check("R10 replay beats read in same cycle", rd_data, x);
    get(v);
    check("R10 first piece after second replay", v, e[1] & low_mask(10));
    mark = 1'b0; tick();
    retx = 1'b1; tick(); retx = 1'b0;
    get(v);
    check("R10 replay without mark ignored", v, (e[1] >> 10) & low_mask(10));

    // R11 held mark keeps consumed entries counted
    master(2'd0, 2'd0, 1'b0);
    mark = 1'b1; tick();
    for (int i = 0; i < DP; i++) put(pat(i, 5));
    for (int i = 0; i < 3; i++) get(v);
    check1("R11 still full while mark held", wr_flag, 1'b1);
    mark = 1'b0; tick();
    check1("R11 full clears when mark released", wr_flag, 1'b0);

    // R12 partial reset keeps configuration, master reset reloads it
    master(2'd0, 2'd1, 1'b0);
    put(40'h11_1111_1111); put(40'h22_2222_2222);
    prst = 1'b1; tick(); prst = 1'b0;
    check1("R12/R2 empty after partial reset", rd_flag, 1'b1);
    check("R12/R2 rd_data cleared by partial reset", rd_data, '0);
    x = 40'h9A_BCDE_F012;
    put(x);
    get(v);
    check("R12 half-width kept: low half", v, x & low_mask(20));
    get(v);
    check("R12 half-width kept: high half", v, x >> 20);
    master(2'd0, 2'd0, 1'b0);
    put(x);
    get(v);
    check("R12 master reset loads full width", v, x);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule